// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural general register file of a processor core that runs in several privilege modes. It holds sixteen data registers. Some of them are physically duplicated so that each exception mode gets private copies, and it keeps one saved-status word for each bank. The core reads two operands, writes one result and reads or writes the saved-status word of the current mode each cycle. A separate mode input, loaded by a strobe, chooses which physical copies those accesses reach.

A mode change takes effect at the next clock edge. No values are copied: every logical register index is steered to a physical slot chosen by the current bank. The same-mode request, the shared user/system set and the deeper banking of the fast-interrupt mode all follow from that steering.

Top module: `bankedRegFile`

## Requirements
- R1: On reset all sixteen registers, every banked copy and every saved-status word read back as zero, and the current mode is system (5'b11111).
- R2: When `modeChange` is high at a clock edge, `curMode` takes the value of `modeIn`. Otherwise `curMode` holds.
- R3: User mode (5'b10000), system mode (5'b11111) and any unrecognised mode code all use the same unbanked set of sixteen registers and share one saved-status word.
- R4: Fast-interrupt mode (5'b10001) has private copies of registers 8 to 12, 13 and 14.
- R5: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private copies of registers 13 and 14 only. Their registers 8 to 12 are the unbanked ones.
- R6: Registers 0 to 7 and 15 are the same physical registers in every mode.
- R7: Each of the five banked modes has its own saved-status word. `spsrRdData` shows the word of the current mode, and a write through `spsrWrEn` appears there from the next cycle.
- R8: A register or saved-status write in the same cycle as a mode change lands in the bank of the new mode.
- R9: Requesting the mode that is already current changes no register and no saved-status word.
- R10: Both read ports are combinational and independent. Each returns the register at its address under the current mode, and a write is visible on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeIn | input | 5 | Requested mode code |
| modeChange | input | 1 | Load `modeIn` as the current mode |
| curMode | output | 5 | Current mode code |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Write register index |
| wrData | input | DATA_W | Write data |
| spsrWrEn | input | 1 | Saved-status write enable |
| spsrWrData | input | DATA_W | Saved-status write data |
| spsrRdData | output | DATA_W | Saved-status word of the current mode |

## Verification
All sixteen indices are written in the unbanked modes and then read back after moves into fast-interrupt, into the stack-only modes and into an unrecognised code. This tells apart a register that is really private from one that only looks banked because it was never written. Moves between two stack-only modes show whether registers 8 to 12 wrongly follow the fast-interrupt copies. Writes placed in the cycle of a mode change, and requests for the current mode, show which bank a coincident write reaches and whether a no-op request disturbs anything. Long random runs then mix mode codes, writes and saved-status traffic against a bench model.

// File: rtl/bankRegPkg.sv
package bankRegPkg;
  localparam int MODE_W    = 5;
  localparam int ARCH_REGS = 16;
  localparam int ADDR_W    = $clog2(ARCH_REGS);
  localparam int FAST_LO   = 8;
  localparam int FAST_HI   = 12;
  localparam int FAST_CNT  = FAST_HI - FAST_LO + 1;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam int NUM_BANKS = 6;
  localparam int PAIR_BASE = ARCH_REGS + FAST_CNT;
  localparam int PHYS_REGS = PAIR_BASE + 2 * (NUM_BANKS - 1);
  localparam int PHYS_W    = $clog2(PHYS_REGS);

  localparam logic [MODE_W-1:0] MODE_USR  = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FAST = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ  = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT  = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND  = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS  = 5'b11111;

  typedef enum logic [2:0] {
    BANK_BASE = 3'd0,
    BANK_FAST = 3'd1,
    BANK_IRQ  = 3'd2,
    BANK_SVC  = 3'd3,
    BANK_ABT  = 3'd4,
    BANK_UND  = 3'd5
  } bankSel_e;

  typedef struct packed {
    logic     regWr;
    logic     spsrWr;
    bankSel_e wrBank;
    bankSel_e rdBank;
  } bankCtl_t;

  function automatic bankSel_e modeToBank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FAST: return BANK_FAST;
      MODE_IRQ:  return BANK_IRQ;
      MODE_SVC:  return BANK_SVC;
      MODE_ABT:  return BANK_ABT;
      MODE_UND:  return BANK_UND;
      default:   return BANK_BASE;
    endcase
  endfunction
endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              modeChange,
  input  logic              wrEn,
  input  logic              spsrWrEn,
  output bankCtl_t          ctl,
  output logic [MODE_W-1:0] curMode
);
  logic [MODE_W-1:0] modeQ;
  bankSel_e          curBank;
  bankSel_e          nextBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_SYS;
    else if (modeChange) modeQ <= modeIn;
  end

  always_comb begin
    curBank    = modeToBank(modeQ);
    nextBank   = modeChange ? modeToBank(modeIn) : curBank;
    ctl.regWr  = wrEn;
    ctl.spsrWr = spsrWrEn;
    ctl.rdBank = curBank;
    ctl.wrBank = nextBank;
  end

  assign curMode = modeQ;
endmodule

// File: rtl/bankDatapath.sv
module bankDatapath
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtl_t          ctl,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] spsrRdData
);
  logic [DATA_W-1:0] physRegs [PHYS_REGS];
  logic [DATA_W-1:0] spsrWords [NUM_BANKS];
  logic [PHYS_W-1:0] wrIdx;
  logic [PHYS_W-1:0] rdIdxA;
  logic [PHYS_W-1:0] rdIdxB;

  // Steer a logical index to its physical slot for the given bank.
  function automatic logic [PHYS_W-1:0] physIndex(input bankSel_e b,
                                                   input logic [ADDR_W-1:0] a);
    int idx;
    idx = int'(a);
    if (b == BANK_FAST && idx >= FAST_LO && idx <= FAST_HI)
      idx = ARCH_REGS + idx - FAST_LO;
    else if (b != BANK_BASE && (idx == SP_IDX || idx == LR_IDX))
      idx = PAIR_BASE + 2 * (int'(b) - 1) + idx - SP_IDX;
    return PHYS_W'(idx);
  endfunction

  assign wrIdx  = physIndex(ctl.wrBank, wrAddr);
  assign rdIdxA = physIndex(ctl.rdBank, rdAddrA);
  assign rdIdxB = physIndex(ctl.rdBank, rdAddrB);

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_phys
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) physRegs[g] <= '0;
      else if (ctl.regWr && wrIdx == PHYS_W'(g)) physRegs[g] <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_spsr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) spsrWords[g] <= '0;
      else if (ctl.spsrWr && int'(ctl.wrBank) == g) spsrWords[g] <= spsrWrData;
    end
  end

  assign rdDataA    = physRegs[rdIdxA];
  assign rdDataB    = physRegs[rdIdxB];
  assign spsrRdData = spsrWords[ctl.rdBank];
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              modeChange,
  output logic [MODE_W-1:0] curMode,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrRdData
);
  bankCtl_t ctl;

  bankCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeChange(modeChange),
    .wrEn(wrEn), .spsrWrEn(spsrWrEn), .ctl(ctl), .curMode(curMode)
  );

  bankDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData),
    .spsrWrData(spsrWrData), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .spsrRdData(spsrRdData)
  );
endmodule

// File: rtl/bankedRegFileChk.sv
module bankedRegFileChk
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeIn,
  input logic              modeChange,
  input logic [MODE_W-1:0] curMode,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              spsrWrEn,
  input logic [DATA_W-1:0] spsrWrData,
  input logic [DATA_W-1:0] spsrRdData
);
  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> curMode == $past(modeIn));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeChange |=> $stable(curMode));

  // R10
  port_a_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdAddrA != $past(wrAddr) || rdDataA == $past(wrData)));

  // R10
  port_b_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdAddrB != $past(wrAddr) || rdDataB == $past(wrData)));

  // R7
  spsr_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |=> spsrRdData == $past(spsrWrData));

  // R6
  shared_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeChange && !wrEn) |=>
      (rdAddrA != $past(rdAddrA) || (rdAddrA >= 4'd8 && rdAddrA != 4'd15) || $stable(rdDataA)));

  // R9
  same_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeChange && modeIn == curMode && !wrEn && !spsrWrEn) |=>
      ($stable(spsrRdData) && (rdAddrA != $past(rdAddrA) || $stable(rdDataA))));
endmodule

bind bankedRegFile bankedRegFileChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeChange(modeChange),
  .curMode(curMode), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData),
  .spsrRdData(spsrRdData)
);

// File: tb/test_bankedRegFile.sv
`timescale 1ns/1ps
module test_bankedRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  modeIn = 5'b11111;
  logic        modeChange = 1'b0;
  logic [4:0]  curMode;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, spsrRdData;
  logic        wrEn = 1'b0, spsrWrEn = 1'b0;
  logic [31:0] wrData = '0, spsrWrData = '0;

  bankedRegFile #(.DATA_W(32)) i_bankedRegFile (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeChange(modeChange),
    .curMode(curMode), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData),
    .spsrRdData(spsrRdData)
  );

  always #2.5 clk = ~clk;

  // Bench model of the architectural state.
  logic [31:0] mBase [16];
  logic [31:0] mFast [5];
  logic [31:0] mPair [6][2];
  logic [31:0] mSaved [6];
  logic [4:0]  mMode;
  int checks = 0;
  int errors = 0;

  function automatic int bankOf(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input int b, input logic [3:0] a);
    if (b == 1 && a >= 8 && a <= 12) return mFast[a - 8];
    if (b != 0 && (a == 13 || a == 14)) return mPair[b][a - 13];
    return mBase[a];
  endfunction

  task automatic modelWrite(input int b, input logic [3:0] a, input logic [31:0] d);
    if (b == 1 && a >= 8 && a <= 12) mFast[a - 8] = d;
    else if (b != 0 && (a == 13 || a == 14)) mPair[b][a - 13] = d;
    else mBase[a] = d;
  endtask

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drives one cycle, checks reads, updates model.
  task automatic cycle(input string req, input logic mc, input logic [4:0] mi,
                       input logic we, input logic [3:0] wa, input logic [31:0] wd,
                       input logic swe, input logic [31:0] swd,
                       input logic [3:0] ra, input logic [3:0] rb);
    int nb;
    modeChange = mc; modeIn = mi; wrEn = we; wrAddr = wa; wrData = wd;
    spsrWrEn = swe; spsrWrData = swd; rdAddrA = ra; rdAddrB = rb;
    #1;
    cmp(req, rdDataA, expRead(bankOf(mMode), ra));
    cmp(req, rdDataB, expRead(bankOf(mMode), rb));
    cmp(req, spsrRdData, mSaved[bankOf(mMode)]);
    cmp("R2", 32'(curMode), 32'(mMode));
    @(posedge clk);
    nb = mc ? bankOf(mi) : bankOf(mMode);
    if (we) modelWrite(nb, wa, wd);
    if (swe) mSaved[nb] = swd;
    if (mc) mMode = mi;
    @(negedge clk);
  endtask

  task automatic idle(input string req, input logic [3:0] ra, input logic [3:0] rb);
    cycle(req, 1'b0, 5'b0, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, ra, rb);
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 16; i++) idle(req, 4'(i), 4'(15 - i));
  endtask

  task automatic goMode(input string req, input logic [4:0] m);
    cycle(req, 1'b1, m, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 4'd0, 4'd0);
  endtask

  task automatic writeAll(input string req, input logic [31:0] tag);
    for (int i = 0; i < 16; i++)
      cycle(req, 1'b0, 5'b0, 1'b1, 4'(i), tag + 32'(i), 1'b0, 32'd0, 4'(i), 4'd0);
  endtask

  function automatic logic [4:0] pickMode(input int r);
    case (r % 8)
      0: return 5'b10000;
      1: return 5'b10001;
      2: return 5'b10010;
      3: return 5'b10011;
      4: return 5'b10111;
      5: return 5'b11011;
      6: return 5'b11111;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL R10: watchdog actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) mBase[i] = '0;
    for (int i = 0; i < 5; i++) mFast[i] = '0;
    for (int i = 0; i < 6; i++) begin
      mPair[i][0] = '0; mPair[i][1] = '0; mSaved[i] = '0;
    end
    mMode = 5'b11111;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readAll("R1");
    // R3: fill unbanked set in system, view it from user and an unknown code
    writeAll("R3", 32'h1000_0000);
    cycle("R7", 1'b0, 5'b0, 1'b0, 4'd0, 32'd0, 1'b1, 32'h5A5A_0000, 4'd0, 4'd1);
    goMode("R3", 5'b10000);
    readAll("R3");
    goMode("R3", 5'b00101);
    readAll("R3");
    // R4: fast-interrupt copies start empty, then keep their own values
    goMode("R4", 5'b10001);
    readAll("R4");
    writeAll("R4", 32'h4000_0000);
    cycle("R7", 1'b0, 5'b0, 1'b0, 4'd0, 32'd0, 1'b1, 32'h5A5A_0001, 4'd8, 4'd13);
    goMode("R4", 5'b11111);
    readAll("R4");
    // R5: stack-only modes
    goMode("R5", 5'b10010);
    readAll("R5");
    writeAll("R5", 32'h5200_0000);
    goMode("R5", 5'b10011);
    readAll("R5");
    writeAll("R6", 32'h6300_0000);
    goMode("R6", 5'b10001);
    readAll("R6");
    goMode("R5", 5'b10010);
    readAll("R5");
    // R8: writes coincident with a mode change
    cycle("R8", 1'b1, 5'b10111, 1'b1, 4'd13, 32'hABCD_0013, 1'b1, 32'h5A5A_0004, 4'd13, 4'd14);
    readAll("R8");
    goMode("R8", 5'b10010);
    readAll("R8");
    // R9: request current mode
    goMode("R9", 5'b10010);
    readAll("R9");
    goMode("R7", 5'b11011);
    cycle("R7", 1'b0, 5'b0, 1'b0, 4'd0, 32'd0, 1'b1, 32'h5A5A_0005, 4'd14, 4'd0);
    idle("R7", 4'd14, 4'd13);
    // R10: random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      cycle("R10", r < 15, pickMode(int'($urandom)), ($urandom % 2) == 1,
            4'($urandom), $urandom, ($urandom % 5) == 0, $urandom,
            4'($urandom), 4'($urandom));
    end
    readAll("R10");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule